// File: doc/BRIEF.md
# Clock Bank Divider with Skew

This block generates the output clock of one clock bank. It runs on a fast timing clock in which every cycle is one skew time unit. One oscillator period spans 16 ticks in the low and mid frequency modes and 8 ticks in the high frequency mode. The block divides the oscillator rate by an integer from 1 to 32 and can invert the result. It can also move the output edges by a signed number of ticks, so that the output leads or lags the reference.

A synchronous enable chooses between the running clock and a disabled state. The disabled state is a steady high level, a steady low level or high impedance, and high impedance is shown as a separate output-enable signal. Power-down and reset restart the divider, so the output edges keep a fixed relation to the release point for every divide setting. Configuration is taken at output period boundaries. A parameter selects which of two skew value sets the bank accepts.

Top module: `clkbank_skew`

## Requirements
- R1: The output period is P = (cfgDiv + 1) * T ticks, where cfgDiv is an unsigned 5-bit field (0 gives ratio 1, 31 gives ratio 32) and T is the tick count per oscillator period.
- R2: T is 16 when cfgHiFreq is 0 and 8 when cfgHiFreq is 1.
- R3: Counting from its rising edge, the output is high for floor(P/2) ticks and low for the rest of the period. When cfgInv is 1 the waveform is inverted.
- R4: Phase alignment after release. Edges are counted from 0 at the first rising clock edge that samples pwrDn low. Rising edge n (with zero skew) presents period phase n mod P, so the output is high after edge 0.
- R5: cfgSkew is a 4-bit two's-complement value s. The output rising edge is at phase s mod P. A positive s delays the edge by s ticks, and a negative s makes it lead by |s| ticks.
- R6: The variant with EVEN_BANK=0 accepts s in the range -4 to +4. Any other value leaves the last accepted skew in force, and skewRej is high while cfgSkew holds that value.
- R7: The variant with EVEN_BANK=1 accepts s in {-6, -4, -2, -1, 0, 1, 2, 4, 6}. Any other value leaves the last accepted skew in force, and skewRej is high while cfgSkew holds that value.
- R8: cfgDiv, cfgHiFreq, cfgInv and cfgSkew are sampled at the edge on which the phase counter wraps from P-1 to 0, and at every edge while pwrDn is high. Changes at other times have no effect until then.
- R9: When disabled, the disabled level depends on cfgDisMode. 00 holds clkOut low, 01 holds clkOut high, and 10 or 11 drive clkOe low (high impedance).
- R10: cfgEnable and cfgDisMode take effect only at the edge that presents the waveform's rising-edge phase, and at every edge while pwrDn is high. No pulse is truncated this way.
- R11: clkOe is low while rstN is low, and after every clock edge that samples pwrDn high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing tick clock, one skew unit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDn | input | 1 | Synchronous power-down; release realigns the divider |
| cfgDiv | input | 5 | Divide ratio minus one |
| cfgHiFreq | input | 1 | 1 selects 8 ticks per oscillator period, 0 selects 16 |
| cfgInv | input | 1 | Inverts the output waveform |
| cfgSkew | input | 4 | Signed skew in ticks |
| cfgEnable | input | 1 | Synchronous output enable |
| cfgDisMode | input | 2 | Disabled level: 00 low, 01 high, 1x high impedance |
| clkOut | output | 1 | Bank output clock |
| clkOe | output | 1 | Output driver enable; low means high impedance |
| skewRej | output | 1 | High while cfgSkew is not accepted by this variant |

## Verification
The bench builds two instances from the same stimulus: the default variant (EVEN_BANK=0) and the even variant (EVEN_BANK=1). One sweep over the union of both skew sets therefore hits accepted values on one instance and rejected, retained values on the other. In high frequency mode the sweep covers every divide ratio with every skew. In low frequency mode it covers ratios 1 to 16 with every skew and the larger ratios with the extreme skews, so both the 8-tick minimum period and the 512-tick maximum period are reached. Mid-period configuration changes, enable and mode toggles, and power-down and reset pulses are checked against the model on every clock.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;   // power-down: counter parked, config loading
    logic load;   // config sample edge (hold or period wrap)
  } bankStrobe_t;

  typedef enum logic [1:0] {
    DIS_LOW  = 2'b00,
    DIS_HIGH = 2'b01,
    DIS_Z0   = 2'b10,
    DIS_Z1   = 2'b11
  } disMode_e;

  function automatic logic oddSkewOk(input int s);
    return (s >= -4) && (s <= 4);
  endfunction

  function automatic logic evenSkewOk(input int s);
    int mag;
    mag = (s < 0) ? -s : s;
    return (mag == 0) || (mag == 1) || (mag == 2) || (mag == 4) || (mag == 6);
  endfunction

endpackage

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
  import clkbank_pkg::*;
#(
  parameter int PER_W    = 10,
  parameter int DIV_W    = 5,
  parameter int TICKS_LO = 16,
  parameter int TICKS_HI = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrDn,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgHiFreq,
  output bankStrobe_t      strb,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] period,
  output logic [PER_W-1:0] periodNew
);

  logic [PER_W-1:0] ratio;
  logic [PER_W-1:0] ticksSel;
  logic             wrap;

  assign ratio     = PER_W'(cfgDiv) + PER_W'(1);
  assign ticksSel  = cfgHiFreq ? PER_W'(TICKS_HI) : PER_W'(TICKS_LO);
  assign periodNew = ratio * ticksSel;

  assign wrap      = (cnt == (period - PER_W'(1)));
  assign strb.hold = pwrDn;
  assign strb.load = pwrDn | wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      period <= PER_W'(TICKS_LO);
    end else if (strb.load) begin
      cnt    <= '0;
      period <= periodNew;
    end else begin
      cnt    <= cnt + PER_W'(1);
    end
  end

endmodule

// File: rtl/clkbank_dp.sv
module clkbank_dp
  import clkbank_pkg::*;
#(
  parameter int PER_W     = 10,
  parameter int SKEW_W    = 4,
  parameter bit EVEN_BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [PER_W-1:0]  cnt,
  input  logic [PER_W-1:0]  period,
  input  logic [PER_W-1:0]  periodNew,
  input  logic              cfgInv,
  input  logic [SKEW_W-1:0] cfgSkew,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgDisMode,
  output logic              clkOut,
  output logic              clkOe,
  output logic              skewRej
);

  int                       skewInt;
  logic                     skewOk;
  logic signed [SKEW_W-1:0] skewQ;
  logic signed [SKEW_W-1:0] skewSel;
  logic        [PER_W-1:0]  skMag;
  logic        [PER_W-1:0]  offNext;
  logic        [PER_W-1:0]  offQ;
  logic                     invQ;
  logic        [PER_W:0]    phSum;
  logic        [PER_W-1:0]  phase;
  logic                     phaseZero;
  logic                     rawLvl;
  logic                     outQ;
  logic                     activeQ;
  logic                     enQ;
  disMode_e                 modeQ;

  assign skewInt = int'($signed(cfgSkew));

  generate
    if (EVEN_BANK) begin : g_even
      assign skewOk = evenSkewOk(skewInt);
    end else begin : g_odd
      assign skewOk = oddSkewOk(skewInt);
    end
  endgenerate

  assign skewRej = ~skewOk;

  // Offset added to the counter so the rising edge sits at phase s mod P
  always_comb begin
    skewSel = skewOk ? $signed(cfgSkew) : skewQ;
    if (skewSel[SKEW_W-1]) skMag = PER_W'(unsigned'(-skewSel));
    else                   skMag = PER_W'(unsigned'(skewSel));
    if (skewSel == '0)          offNext = '0;
    else if (skewSel[SKEW_W-1]) offNext = skMag;
    else                        offNext = periodNew - skMag;
  end

  assign phSum     = {1'b0, cnt} + {1'b0, offQ};
  assign phase     = (phSum >= {1'b0, period}) ? PER_W'(phSum - {1'b0, period})
                                               : PER_W'(phSum);
  assign phaseZero = (phase == '0);
  assign rawLvl    = (phase < (period >> 1)) ^ invQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ    <= '0;
      skewQ   <= '0;
      invQ    <= 1'b0;
      outQ    <= 1'b0;
      activeQ <= 1'b0;
      enQ     <= 1'b0;
      modeQ   <= DIS_LOW;
    end else begin
      if (strb.load) begin
        offQ <= offNext;
        invQ <= cfgInv;
        if (skewOk) skewQ <= $signed(cfgSkew);
      end
      activeQ <= ~strb.hold;
      outQ    <= strb.hold ? 1'b0 : rawLvl;
      if (strb.hold || phaseZero) begin
        enQ   <= cfgEnable;
        modeQ <= disMode_e'(cfgDisMode);
      end
    end
  end

  assign clkOut = enQ ? outQ : (modeQ == DIS_HIGH);
  assign clkOe  = activeQ & (enQ | ~modeQ[1]);

endmodule

// File: rtl/clkbank_skew.sv
module clkbank_skew
  import clkbank_pkg::*;
#(
  parameter bit EVEN_BANK = 1'b0,
  parameter int DIV_W     = 5,
  parameter int SKEW_W    = 4,
  parameter int TICKS_LO  = 16,
  parameter int TICKS_HI  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDn,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              cfgHiFreq,
  input  logic              cfgInv,
  input  logic [SKEW_W-1:0] cfgSkew,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgDisMode,
  output logic              clkOut,
  output logic              clkOe,
  output logic              skewRej
);

  localparam int MAX_PER = (2 ** DIV_W) * TICKS_LO;
  localparam int PER_W   = $clog2(MAX_PER + 1);

  bankStrobe_t      strb;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] periodNew;

  clkbank_ctrl #(
    .PER_W(PER_W), .DIV_W(DIV_W), .TICKS_LO(TICKS_LO), .TICKS_HI(TICKS_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .cfgDiv(cfgDiv), .cfgHiFreq(cfgHiFreq),
    .strb(strb), .cnt(cnt), .period(period), .periodNew(periodNew)
  );

  clkbank_dp #(
    .PER_W(PER_W), .SKEW_W(SKEW_W), .EVEN_BANK(EVEN_BANK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .period(period),
    .periodNew(periodNew), .cfgInv(cfgInv), .cfgSkew(cfgSkew),
    .cfgEnable(cfgEnable), .cfgDisMode(cfgDisMode),
    .clkOut(clkOut), .clkOe(clkOe), .skewRej(skewRej)
  );

endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
  parameter int PER_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrDn,
  input logic             clkOe,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] period,
  input logic             hold,
  input logic             load
);

  // R11
  oe_low_in_pwrdn_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |=> !clkOe);

  // R1
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt < period);

  // R8
  period_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(period) |-> $past(load));

  // R4
  realign_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hold) |-> (cnt == '0));

endmodule

bind clkbank_skew clkbank_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .clkOe(clkOe),
  .cnt(cnt), .period(period), .hold(strb.hold), .load(strb.load)
);

// File: tb/test_clkbank_skew.sv
`timescale 1ns/100ps
module test_clkbank_skew;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrDn = 1'b1;
  logic [4:0] cfgDiv = '0;
  logic       cfgHiFreq = 1'b0;
  logic       cfgInv = 1'b0;
  logic [3:0] cfgSkew = '0;
  logic       cfgEnable = 1'b1;
  logic [1:0] cfgDisMode = 2'b00;
  logic [1:0] outA, oeA, rejA;

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R11";
  bit    done = 0;

  always #2 clk = ~clk;

  clkbank_skew #(.EVEN_BANK(1'b0)) i_clkbank_skew (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .cfgDiv(cfgDiv), .cfgHiFreq(cfgHiFreq),
    .cfgInv(cfgInv), .cfgSkew(cfgSkew), .cfgEnable(cfgEnable), .cfgDisMode(cfgDisMode),
    .clkOut(outA[0]), .clkOe(oeA[0]), .skewRej(rejA[0]));

  clkbank_skew #(.EVEN_BANK(1'b1)) i_clkbank_skew_even (
    .clk(clk), .rstN(rstN), .pwrDn(pwrDn), .cfgDiv(cfgDiv), .cfgHiFreq(cfgHiFreq),
    .cfgInv(cfgInv), .cfgSkew(cfgSkew), .cfgEnable(cfgEnable), .cfgDisMode(cfgDisMode),
    .clkOut(outA[1]), .clkOe(oeA[1]), .skewRej(rejA[1]));

  // Behavioural reference, one entry per variant (0 odd, 1 even)
  int mC[2], mP[2], mS[2], mInv[2], mEn[2], mMode[2], mAct[2], mOut[2];

  function automatic bit skOk(int s, int v);
    if (v == 0) return (s >= -4 && s <= 4);
    return (s == -6 || s == -4 || s == -2 || s == -1 || s == 0 ||
            s == 1 || s == 2 || s == 4 || s == 6);
  endfunction

  function automatic int skInt();
    return cfgSkew[3] ? int'(cfgSkew) - 16 : int'(cfgSkew);
  endfunction

  task automatic latchCfg(int v);
    if (skOk(skInt(), v)) mS[v] = skInt();
    mP[v] = (int'(cfgDiv) + 1) * (cfgHiFreq ? 8 : 16);
    mInv[v] = int'(cfgInv);
  endtask

  always @(posedge clk or negedge rstN) begin
    for (int v = 0; v < 2; v++) begin
      if (!rstN) begin
        mC[v] = 0; mP[v] = 16; mS[v] = 0; mInv[v] = 0;
        mEn[v] = 0; mMode[v] = 0; mAct[v] = 0; mOut[v] = 0;
      end else if (pwrDn) begin
        mAct[v] = 0; mC[v] = 0; mOut[v] = 0;
        latchCfg(v);
        mEn[v] = int'(cfgEnable); mMode[v] = int'(cfgDisMode);
      end else begin
        int w;
        w = ((mC[v] - mS[v]) % mP[v] + mP[v]) % mP[v];
        mAct[v] = 1;
        mOut[v] = ((w < mP[v] / 2) ? 1 : 0) ^ mInv[v];
        if (w == 0) begin
          mEn[v] = int'(cfgEnable); mMode[v] = int'(cfgDisMode);
        end
        if (mC[v] == mP[v] - 1) begin
          mC[v] = 0; latchCfg(v);
        end else begin
          mC[v] = mC[v] + 1;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int v = 0; v < 2; v++) begin
        logic eo, eq;
        eo = (mAct[v] != 0) && (mEn[v] != 0 || mMode[v] < 2);
        eq = (mEn[v] != 0) ? logic'(mOut[v] != 0) : logic'(mMode[v] == 1);
        compared++;
        if (oeA[v] !== eo || (eo && outA[v] !== eq)) begin
          mismatched++;
          $display("FAIL %s variant %0d: oe/out actual %b/%b expected %b/%b",
                   curReq, v, oeA[v], outA[v], eo, eq);
        end
      end
    end
  end

  task automatic runCase(int d, int hi, int inv, int sk);
    @(negedge clk); #1;
    cfgDiv = d[4:0]; cfgHiFreq = hi[0]; cfgInv = inv[0]; cfgSkew = sk[3:0]; pwrDn = 1'b1;
    repeat (2) @(negedge clk);
    #1 pwrDn = 1'b0;
    repeat ((d + 1) * (hi != 0 ? 8 : 16) + 2) @(negedge clk);
  endtask

  task automatic checkRej(int sk, logic expOdd, logic expEven, string tag);
    @(negedge clk); #1 cfgSkew = sk[3:0];
    #0.5;
    compared += 2;
    if (rejA[0] !== expOdd) begin
      mismatched++;
      $display("FAIL %s skewRej odd skew %0d: actual %b expected %b", tag, sk, rejA[0], expOdd);
    end
    if (rejA[1] !== expEven) begin
      mismatched++;
      $display("FAIL %s skewRej even skew %0d: actual %b expected %b", tag, sk, rejA[1], expEven);
    end
  endtask

  int skList[11] = '{-6, -4, -3, -2, -1, 0, 1, 2, 3, 4, 6};

  initial begin
    // R11: reset state
    curReq = "R11";
    repeat (4) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep: R1 R2 R3 R4 R5 R6 R7
    curReq = "R1 R2 R3 R4 R5 R6 R7";
    for (int d = 0; d < 32; d++)
      for (int k = 0; k < 11; k++)
        runCase(d, 1, d % 2, skList[k]);
    for (int d = 0; d < 16; d++)
      for (int k = 0; k < 11; k++)
        runCase(d, 0, (d + k) % 2, skList[k]);
    for (int d = 16; d < 32; d++) begin
      runCase(d, 0, 0, -6);
      runCase(d, 0, 1, 0);
      runCase(d, 0, 0, 6);
    end

    // Skew acceptance flags
    checkRej(3, 1'b0, 1'b1, "R6 R7");
    checkRej(5, 1'b1, 1'b1, "R6 R7");
    checkRej(-6, 1'b1, 1'b0, "R6 R7");
    checkRej(-1, 1'b0, 1'b0, "R6 R7");
    checkRej(-8, 1'b1, 1'b1, "R6 R7");

    // R8: mid-period config changes take effect at the wrap
    curReq = "R8";
    runCase(3, 0, 0, 2);
    repeat (17) @(negedge clk);
    #1 cfgDiv = 5'd1;
    repeat (150) @(negedge clk);
    #1 begin cfgSkew = 4'hd; cfgInv = 1'b1; cfgHiFreq = 1'b1; end
    repeat (150) @(negedge clk);
    #1 begin cfgSkew = 4'd5; cfgDiv = 5'd2; end
    repeat (150) @(negedge clk);

    // R9 R10: synchronous enable and disabled levels
    curReq = "R9 R10";
    runCase(2, 0, 0, 3);
    repeat (11) @(negedge clk);
    #1 begin cfgEnable = 1'b0; cfgDisMode = 2'b01; end
    repeat (130) @(negedge clk);
    #1 cfgEnable = 1'b1;
    repeat (77) @(negedge clk);
    #1 begin cfgEnable = 1'b0; cfgDisMode = 2'b00; end
    repeat (130) @(negedge clk);
    #1 cfgDisMode = 2'b10;
    repeat (130) @(negedge clk);
    #1 cfgDisMode = 2'b11;
    repeat (60) @(negedge clk);
    #1 cfgEnable = 1'b1;
    repeat (130) @(negedge clk);

    // R11 R4: power-down and reset in mid run
    curReq = "R11 R4";
    #1 pwrDn = 1'b1;
    repeat (5) @(negedge clk);
    #1 pwrDn = 1'b0;
    repeat (100) @(negedge clk);
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (40) @(negedge clk);
    #1 pwrDn = 1'b1;
    repeat (3) @(negedge clk);
    #1 pwrDn = 1'b0;
    repeat (100) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    done = 1;
    mismatched++;
    $display("FAIL watchdog %s: actual timeout expected completion", curReq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule